// File: doc/BRIEF.md
# ADC Result Byte Register with Selectable Justification

This block holds the most recent 10-bit conversion result and shows it to an 8-bit register read bus as two bytes, a high byte and a low byte. A 2-bit layout select decides how the ten result bits are split across the two bytes. In right-justified layout the result sits at the bottom of the 16-bit pair. In left-justified layout it sits at the top. A signed variant of the left layout inverts the result's most significant bit, which turns an offset-binary value into two's complement.

Software reads the high byte first and then the low byte. A high-byte read locks the stored result, so the low byte read afterwards belongs to the same conversion. While the lock is held, every conversion-done strobe is dropped and never queued. The read of the low byte releases the lock. The stored result has no reset value and survives a reset. Reset only releases the lock.

Top module: `adcres_regs`

## Requirements
- R1: When `mode` is 2'b00, the high byte (`reg_sel`=1) reads {6'b0, result[9:8]}.
- R2: When `mode` is 2'b00, the low byte (`reg_sel`=0) reads result[7:0].
- R3: When `mode` is 2'b01, the high byte reads result[9:2] and the low byte reads {result[1:0], 6'b0}.
- R4: When `mode` is 2'b10, the layout is the same as in R3, except that bit 7 of the high byte is the inverse of result[9].
- R5: `mode` 2'b11 reads exactly as right-justified (R1, R2).
- R6: A `conv_done` pulse with no lock held, and with no high-byte read in the same cycle, stores `conv_data`. `rd_data` reflects the new value from the next cycle on.
- R7: A cycle with `rd_en`=1 and `reg_sel`=1 sets the lock. The conversion result is then held, and every `conv_done` is discarded until the lock ends. This includes a `conv_done` in the same cycle as the high-byte read.
- R8: A low-byte read while the lock is held ends the lock. A `conv_done` in that same cycle is discarded.
- R9: A low-byte read with no lock held returns the current low byte and leaves the lock clear, so the next conversion is accepted.
- R10: Reset releases the lock but leaves the stored result unchanged.
- R11: The layout is taken from `mode` at the time of each read and applied to the stored result. This holds while the lock is held as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; releases the lock only |
| conv_done | input | 1 | Single-cycle strobe: a new conversion result is present |
| conv_data | input | 10 | Conversion result, valid with `conv_done` |
| mode | input | 2 | Layout: 00 right, 01 left unsigned, 10 left signed, 11 right |
| reg_sel | input | 1 | Byte select: 1 high byte, 0 low byte |
| rd_en | input | 1 | Read strobe for the selected byte |
| rd_data | output | 8 | Selected byte in the current layout (combinational) |

## Verification
The checker treats `rd_en` as a single-cycle strobe, each cycle counting as one read access. It also assumes the stored result has been written by at least one accepted conversion before any check compares data. The bench therefore starts with a conversion and compares `rd_data` only after its model has seen a result accepted. All stimulus changes on the falling edge. The collision cases are driven on purpose: a strobe in the same cycle as a high-byte read, a strobe in the same cycle as the lock-ending low-byte read, and a mode change while the lock is held.

// File: rtl/adcres_pkg.sv
package adcres_pkg;

    localparam int RES_W  = 10;
    localparam int BUS_W  = 8;
    localparam int SPILL_W = RES_W - BUS_W;       // result bits spilling into the other byte
    localparam int HPAD_W  = 2 * BUS_W - RES_W;   // zero pad in a right-justified high byte
    localparam int LPAD_W  = BUS_W - SPILL_W;     // zero pad in a left-justified low byte

    typedef enum logic [1:0] {
        JUST_RIGHT       = 2'b00,
        JUST_LEFT        = 2'b01,
        JUST_LEFT_SIGNED = 2'b10,
        JUST_RSVD        = 2'b11
    } just_e;

    typedef enum logic {
        SEL_LOW  = 1'b0,
        SEL_HIGH = 1'b1
    } bytesel_e;

    typedef struct packed {
        logic             valid;
        logic [RES_W-1:0] data;
    } conv_t;

    typedef struct packed {
        logic     hit;
        bytesel_e which;
    } rdreq_t;

    function automatic logic [BUS_W-1:0] format_byte(
        input just_e            m,
        input bytesel_e         s,
        input logic [RES_W-1:0] raw
    );
        logic [BUS_W-1:0] b;
        if (m == JUST_LEFT || m == JUST_LEFT_SIGNED) begin
            if (s == SEL_HIGH) begin
                b = raw[RES_W-1:SPILL_W];
                if (m == JUST_LEFT_SIGNED) b[BUS_W-1] = ~b[BUS_W-1];
            end else begin
                b = {raw[SPILL_W-1:0], {LPAD_W{1'b0}}};
            end
        end else begin
            if (s == SEL_HIGH) b = {{HPAD_W{1'b0}}, raw[RES_W-1:BUS_W]};
            else               b = raw[BUS_W-1:0];
        end
        return b;
    endfunction

endpackage

// File: rtl/adcres_capture.sv
module adcres_capture
    import adcres_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  conv_t            conv,
    input  rdreq_t           rd,
    output logic [RES_W-1:0] raw_q,
    output logic             locked_q
);

    logic hi_read;
    logic lo_read;
    logic accept;

    assign hi_read = rd.hit && (rd.which == SEL_HIGH);
    assign lo_read = rd.hit && (rd.which == SEL_LOW);
    // a result landing with the high read or during the lock would tear the pair
    assign accept  = conv.valid && !locked_q && !hi_read;

    // stored result deliberately has no reset
    always_ff @(posedge clk) begin
        if (accept) raw_q <= conv.data;
    end

    always_ff @(posedge clk) begin
        if (rst)          locked_q <= 1'b0;
        else if (hi_read) locked_q <= 1'b1;
        else if (lo_read) locked_q <= 1'b0;
    end

endmodule

// File: rtl/adcres_format.sv
module adcres_format
    import adcres_pkg::*;
(
    input  just_e            mode,
    input  bytesel_e         which,
    input  logic [RES_W-1:0] raw,
    output logic [BUS_W-1:0] byte_out
);

    always_comb begin
        byte_out = format_byte(mode, which, raw);
    end

endmodule

// File: rtl/adcres_regs.sv
module adcres_regs
    import adcres_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_data,
    input  logic [1:0]       mode,
    input  logic             reg_sel,
    input  logic             rd_en,
    output logic [BUS_W-1:0] rd_data
);

    conv_t            conv;
    rdreq_t           rdreq;
    logic [RES_W-1:0] raw_q;
    logic             locked_q;

    assign conv.valid  = conv_done;
    assign conv.data   = conv_data;
    assign rdreq.hit   = rd_en;
    assign rdreq.which = bytesel_e'(reg_sel);

    adcres_capture u_capture (
        .clk      (clk),
        .rst      (rst),
        .conv     (conv),
        .rd       (rdreq),
        .raw_q    (raw_q),
        .locked_q (locked_q)
    );

    adcres_format u_format (
        .mode     (just_e'(mode)),
        .which    (rdreq.which),
        .raw      (raw_q),
        .byte_out (rd_data)
    );

endmodule

// File: rtl/adcres_regs_chk.sv
module adcres_regs_chk
    import adcres_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             conv_done,
    input logic [RES_W-1:0] conv_data,
    input logic [1:0]       mode,
    input logic             reg_sel,
    input logic             rd_en,
    input logic [BUS_W-1:0] rd_data,
    input logic [RES_W-1:0] raw_q,
    input logic             locked_q
);

    assert_accept_R6: assert property (@(posedge clk) disable iff (rst)
        (conv_done && !locked_q && !(rd_en && reg_sel)) |=> (raw_q == $past(conv_data)));

    assert_lock_set_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_en && reg_sel) |=> locked_q);

    assert_hold_locked_R7: assert property (@(posedge clk) disable iff (rst)
        locked_q |=> $stable(raw_q));

    assert_lock_end_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !reg_sel && locked_q) |=> (!locked_q && $stable(raw_q)));

    assert_solo_low_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !reg_sel && !locked_q) |=> !locked_q);

    assert_reset_unlock_R10: assert property (@(posedge clk)
        rst |=> !locked_q);

    assert_right_pad_R1: assert property (@(posedge clk) disable iff (rst)
        ((mode == 2'b00 || mode == 2'b11) && reg_sel)
            |-> (rd_data[BUS_W-1:BUS_W-HPAD_W] == '0));

    assert_left_pad_R3: assert property (@(posedge clk) disable iff (rst)
        ((mode == 2'b01 || mode == 2'b10) && !reg_sel)
            |-> (rd_data[LPAD_W-1:0] == '0));

endmodule

bind adcres_regs adcres_regs_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .conv_done (conv_done),
    .conv_data (conv_data),
    .mode      (mode),
    .reg_sel   (reg_sel),
    .rd_en     (rd_en),
    .rd_data   (rd_data),
    .raw_q     (raw_q),
    .locked_q  (locked_q)
);

// File: tb/adcres_regs_tb.sv
module adcres_regs_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       conv_done = 1'b0;
    logic [9:0] conv_data = '0;
    logic [1:0] mode = '0;
    logic       reg_sel = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;

    int checks = 0;
    int failures = 0;

    // behavioural reference state
    int ref_raw = 0;
    bit ref_lock = 0;
    bit ref_valid = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adcres_regs u_dut (
        .clk(clk), .rst(rst), .conv_done(conv_done), .conv_data(conv_data),
        .mode(mode), .reg_sel(reg_sel), .rd_en(rd_en), .rd_data(rd_data)
    );

    function automatic int expect_byte(input int m, input bit hi);
        int v;
        if (m == 1 || m == 2) begin
            if (hi) begin
                v = ref_raw / 4;
                if (m == 2) v = v ^ 128;
            end else v = (ref_raw % 4) * 64;
        end else begin
            v = hi ? ref_raw / 256 : ref_raw % 256;
        end
        return v;
    endfunction

    task automatic step(input string tag, input bit cv, input int d, input int m,
                        input bit hi, input bit rd);
        int exp;
        @(negedge clk);
        conv_done = cv; conv_data = d[9:0]; mode = m[1:0]; reg_sel = hi; rd_en = rd;
        #1;
        if (ref_valid) begin
            exp = expect_byte(m, hi);
            checks++;
            if (rd_data !== exp[7:0]) begin
                failures++;
                $display("FAIL %s rd_data=%02h expected=%02h", tag, rd_data, exp[7:0]);
            end
        end
        @(posedge clk);
        if (cv && !ref_lock && !(rd && hi)) begin
            ref_raw = d;
            ref_valid = 1;
        end
        if (rd && hi) ref_lock = 1;
        else if (rd && !hi) ref_lock = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; conv_done = 0; rd_en = 0;
        @(posedge clk);
        ref_lock = 0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        step("R6",  1, 'h2C5, 0, 1, 0);
        step("R1",  0, 0,     0, 1, 1);   // high read 02, lock
        step("R7",  1, 'h0AA, 0, 0, 0);   // dropped, low shows C5
        step("R2",  0, 0,     0, 0, 1);   // low read C5, unlock
        step("R9",  0, 0,     0, 0, 1);   // solo low read
        step("R9",  1, 'h3F2, 1, 1, 0);   // accepted after solo read
        step("R3",  0, 0,     1, 1, 1);   // FC, lock
        step("R11", 1, 'h001, 2, 0, 0);   // low left 80 under lock
        step("R11", 0, 0,     0, 1, 0);   // right high 03 under lock
        step("R8",  1, 'h155, 1, 0, 1);   // ends lock, conv dropped
        step("R8",  0, 0,     1, 1, 0);   // still FC
        step("R7",  1, 'h2AB, 2, 1, 1);   // conv with high read dropped, 7C
        step("R4",  0, 0,     2, 1, 0);
        step("R4",  0, 0,     2, 0, 1);   // 80, unlock
        step("R6",  1, 'h2AB, 3, 0, 0);
        step("R5",  0, 0,     3, 1, 0);   // 02
        step("R5",  0, 0,     3, 0, 0);   // AB
        step("R4",  0, 0,     2, 1, 0);   // 2A
        step("R3",  0, 0,     1, 0, 0);   // C0

        step("R10", 0, 0,     0, 1, 1);   // lock before reset
        do_reset();
        step("R10", 0, 0,     0, 1, 0);   // stored value survived
        step("R10", 1, 'h100, 0, 0, 0);   // accepted: lock released
        step("R10", 0, 0,     0, 1, 0);   // 01

        for (int i = 0; i < 48; i++) begin
            step("R6", (i % 3) != 2, (i * 37 + 5) % 1024, i % 4,
                 (i % 2) == 0, (i % 5) < 2);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule